// File: doc/BRIEF.md
# Microcode Image Validator and Loader

This block receives a microcode image package as a byte stream, holds it in an internal buffer, and validates it before any of it reaches the processors. The checks cover the package signature, the format version, the number of processor descriptors, the declared size against a size rebuilt from the descriptor contents, and a trailing CRC-32. Only when every check passes does the block replay the buffered image: it sets the instruction-RAM split bit when the image asks for a shared RAM, uploads each descriptor's code words through an auto-incrementing RAM address port, marks the RAM ready, and writes the non-zero trap words into that processor's trap registers.

The input is a valid/ready byte stream. A byte moves on a rising clock edge where both `s_valid` and `s_ready` are high; `s_last` marks the final byte of an image. `s_ready` is high only while the block is collecting an image, and drops for the whole validation and load phase, so the sender must hold its byte and `s_valid` until it sees `s_ready`. The outputs are plain one-cycle write strobes plus a `done`/`err` pair that stays until the next image starts.

Top module: `ucode_loader`

## Requirements
- R1: Image layout, all multi-byte fields big-endian: bytes 0-3 declared total length, bytes 4-6 signature, byte 7 version, byte 8 descriptor count, byte 9 split flag; from byte 10 follow `count` descriptors of 76 bytes each, holding at +0 the RAM start offset, at +4 the byte offset of its code inside the image, at +8 the number of 32-bit code words, and at +12 sixteen trap words. A signature other than the ASCII bytes 0x51 0x45 0x46 ends the image with `err`=1.
- R2: A version byte other than 1 ends the image with `err`=2.
- R3: A descriptor count outside 1..4 ends the image with `err`=3.
- R4: With computed length = 10 + 76*count + 4*(sum of the word counts of the `count` descriptors) + 4, the image ends with `err`=4 when the declared length differs from it, differs from the number of bytes received, or more bytes arrive than the buffer holds.
- R5: A CRC-32 (reflected polynomial 0xEDB88320, initial value 0, no final inversion) over every byte except the last four must equal those four bytes read big-endian, else `err`=5; a fully valid image ends with `err`=0.
- R6: Checks are ranked R1, R2, R3, R4, R5; when several fail, the lowest-numbered code is reported.
- R7: After a valid image, `split_set` pulses exactly once, before any RAM or trap write, when the split flag byte is 0, and never when it is non-zero.
- R8: For each descriptor in order with a non-zero code offset, the RAM port emits one write of kind 1 (address) carrying the RAM offset, then one write of kind 2 (data) per code word in image order, then one write of kind 3 (ready) with data 1.
- R9: A descriptor whose code offset is 0 produces no RAM port write.
- R10: After each descriptor's code upload (or in its place), each non-zero trap word produces one trap write with `trap_cpu` = descriptor index, `trap_sel` = trap index 0..15 and the word as data; zero trap words produce none.
- R11: `s_ready` is high only while an image is being collected; a rejected image causes no RAM, trap or split write; `done` rises with `err` at the end of every image, and `err` is non-zero only while `done` is high.
- R12: `done` and `err` hold their values until the first byte of the next image is accepted, and are both 0 in the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| s_valid | input | 1 | Input byte valid |
| s_ready | output | 1 | Block can take a byte |
| s_data | input | 8 | Input byte |
| s_last | input | 1 | Final byte of the image |
| ram_valid | output | 1 | Instruction-RAM port write strobe |
| ram_kind | output | 2 | 1 address, 2 data word, 3 ready |
| ram_data | output | 32 | Address, code word or ready value |
| split_set | output | 1 | Pulse: set the instruction-RAM split bit |
| trap_we | output | 1 | Trap register write strobe |
| trap_cpu | output | 2 | Processor index of the trap write |
| trap_sel | output | 4 | Trap register index |
| trap_data | output | 32 | Trap word |
| done | output | 1 | Image finished (held) |
| err | output | 3 | Result code, 0 ok, 1..5 as in R1-R5 (held) |

## Verification
On every cycle the assertions check the port-level rules: no RAM write while input is accepted, only non-zero trap words written, the split pulse never coinciding with a write, every RAM write carrying a defined kind, a non-zero result only with `done`, and `done` dropping after a new image's first byte. The exact write sequence, the length arithmetic, the CRC and the ranking of failures can only be shown by the bench's scenarios, which build images, corrupt single fields and compare the recorded writes against lists derived from the image they sent.

// File: rtl/ucl_pkg.sv
package ucl_pkg;
  localparam int HDR_BYTES  = 10;
  localparam int DESC_BYTES = 76;
  localparam int TRAP_OFS   = 12;
  localparam int NUM_TRAPS  = 16;

  localparam logic [2:0] E_NONE  = 3'd0;
  localparam logic [2:0] E_MAGIC = 3'd1;
  localparam logic [2:0] E_VER   = 3'd2;
  localparam logic [2:0] E_CNT   = 3'd3;
  localparam logic [2:0] E_LEN   = 3'd4;
  localparam logic [2:0] E_CRC   = 3'd5;

  localparam logic [1:0] K_ADDR  = 2'd1;
  localparam logic [1:0] K_DATA  = 2'd2;
  localparam logic [1:0] K_READY = 2'd3;

  function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'd0, b};
    for (int k = 0; k < 8; k++)
      r = r[0] ? ((r >> 1) ^ 32'hEDB8_8320) : (r >> 1);
    return r;
  endfunction
endpackage

// File: rtl/ucl_rx.sv
module ucl_rx
  import ucl_pkg::*;
#(
  parameter int BUF_BYTES = 1024,
  parameter int MAX_CPU   = 4,
  localparam int AW       = $clog2(BUF_BYTES)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       acc,
  input  logic [7:0]                 din,
  input  logic [AW-1:0]              rd_addr,
  output logic [7:0]                 rd_byte,
  output logic [31:0]                decl_len,
  output logic [23:0]                magic,
  output logic [7:0]                 version,
  output logic [7:0]                 count,
  output logic [7:0]                 split,
  output logic [MAX_CPU-1:0][31:0]   ram_off,
  output logic [MAX_CPU-1:0][31:0]   code_off,
  output logic [MAX_CPU-1:0][31:0]   wcnt,
  output logic [31:0]                rx_cnt,
  output logic                       ovf,
  output logic [31:0]                crc,
  output logic [31:0]                trailer
);
  logic [7:0] mem [BUF_BYTES];

  always_ff @(posedge clk) begin
    if (acc && rx_cnt < 32'(BUF_BYTES))
      mem[rx_cnt[AW-1:0]] <= din;
  end

  assign rd_byte = mem[rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_cnt <= '0; ovf <= 1'b0; crc <= '0; trailer <= '0;
      decl_len <= '0; magic <= '0; version <= '0; count <= '0; split <= '0;
      ram_off <= '0; code_off <= '0; wcnt <= '0;
    end else if (clr) begin
      rx_cnt <= '0; ovf <= 1'b0; crc <= '0; trailer <= '0;
    end else if (acc) begin
      rx_cnt  <= rx_cnt + 32'd1;
      trailer <= {trailer[23:0], din};
      if (rx_cnt >= 32'd4) crc <= crc32_step(crc, trailer[31:24]);
      if (rx_cnt >= 32'(BUF_BYTES)) ovf <= 1'b1;
      if (rx_cnt < 32'd4) decl_len <= {decl_len[23:0], din};
      if (rx_cnt >= 32'd4 && rx_cnt < 32'd7) magic <= {magic[15:0], din};
      if (rx_cnt == 32'd7) version <= din;
      if (rx_cnt == 32'd8) count   <= din;
      if (rx_cnt == 32'd9) split   <= din;
      for (int g = 0; g < MAX_CPU; g++) begin
        if (rx_cnt >= 32'(HDR_BYTES + DESC_BYTES*g) && rx_cnt < 32'(HDR_BYTES + DESC_BYTES*g + 4))
          ram_off[g] <= {ram_off[g][23:0], din};
        if (rx_cnt >= 32'(HDR_BYTES + DESC_BYTES*g + 4) && rx_cnt < 32'(HDR_BYTES + DESC_BYTES*g + 8))
          code_off[g] <= {code_off[g][23:0], din};
        if (rx_cnt >= 32'(HDR_BYTES + DESC_BYTES*g + 8) && rx_cnt < 32'(HDR_BYTES + DESC_BYTES*g + 12))
          wcnt[g] <= {wcnt[g][23:0], din};
      end
    end
  end
endmodule

// File: rtl/ucl_check.sv
module ucl_check
  import ucl_pkg::*;
#(
  parameter int MAX_CPU = 4
) (
  input  logic [31:0]               decl_len,
  input  logic [23:0]               magic,
  input  logic [7:0]                version,
  input  logic [7:0]                count,
  input  logic [MAX_CPU-1:0][31:0]  wcnt,
  input  logic [31:0]               rx_cnt,
  input  logic                      ovf,
  input  logic [31:0]               crc,
  input  logic [31:0]               trailer,
  output logic [2:0]                err
);
  logic [39:0] words;
  logic [39:0] calc_len;

  always_comb begin
    words = '0;
    for (int i = 0; i < MAX_CPU; i++)
      if (8'(i) < count) words = words + {8'd0, wcnt[i]};
    calc_len = 40'(HDR_BYTES) + 40'(DESC_BYTES) * {32'd0, count} + (words << 2) + 40'd4;
  end

  always_comb begin
    if (magic != 24'h51_45_46)                          err = E_MAGIC;
    else if (version != 8'd1)                           err = E_VER;
    else if (count == 8'd0 || count > 8'(MAX_CPU))      err = E_CNT;
    else if (ovf || {8'd0, decl_len} != calc_len || decl_len != rx_cnt)
                                                        err = E_LEN;
    else if (crc != trailer)                            err = E_CRC;
    else                                                err = E_NONE;
  end
endmodule

// File: rtl/ucl_seq.sv
module ucl_seq
  import ucl_pkg::*;
#(
  parameter int AW      = 10,
  parameter int MAX_CPU = 4,
  localparam int CW     = (MAX_CPU > 1) ? $clog2(MAX_CPU) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [7:0]                count,
  input  logic [7:0]                split,
  input  logic [MAX_CPU-1:0][31:0]  ram_off,
  input  logic [MAX_CPU-1:0][31:0]  code_off,
  input  logic [MAX_CPU-1:0][31:0]  wcnt,
  input  logic [7:0]                rd_byte,
  output logic [AW-1:0]             rd_addr,
  output logic                      ram_valid,
  output logic [1:0]                ram_kind,
  output logic [31:0]               ram_data,
  output logic                      split_set,
  output logic                      trap_we,
  output logic [CW-1:0]             trap_cpu,
  output logic [3:0]                trap_sel,
  output logic [31:0]               trap_data,
  output logic                      fin
);
  typedef enum logic [2:0] {L_IDLE, L_SPLIT, L_DESC, L_CODE, L_RDY, L_TRAP, L_END} lst_e;
  lst_e st;
  logic [CW-1:0] cpu;
  logic [31:0]   widx, baddr;
  logic [3:0]    tsel;
  logic [1:0]    bsel;
  logic [23:0]   acc_b;
  logic [31:0]   word;
  logic [31:0]   trap_base;

  assign rd_addr   = baddr[AW-1:0];
  assign word      = {acc_b, rd_byte};
  assign trap_base = 32'(HDR_BYTES + TRAP_OFS) + 32'(DESC_BYTES) * 32'(cpu);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= L_IDLE; cpu <= '0; widx <= '0; baddr <= '0; tsel <= '0; bsel <= '0; acc_b <= '0;
      ram_valid <= 1'b0; ram_kind <= '0; ram_data <= '0; split_set <= 1'b0;
      trap_we <= 1'b0; trap_cpu <= '0; trap_sel <= '0; trap_data <= '0; fin <= 1'b0;
    end else begin
      ram_valid <= 1'b0; split_set <= 1'b0; trap_we <= 1'b0; fin <= 1'b0;
      unique case (st)
        L_IDLE: if (start) st <= L_SPLIT;
        L_SPLIT: begin
          split_set <= (split == 8'd0);
          cpu <= '0;
          st  <= L_DESC;
        end
        L_DESC: begin
          bsel <= '0;
          if (code_off[cpu] != 32'd0) begin
            ram_valid <= 1'b1; ram_kind <= K_ADDR; ram_data <= ram_off[cpu];
            baddr <= code_off[cpu];
            widx  <= '0;
            st    <= (wcnt[cpu] == 32'd0) ? L_RDY : L_CODE;
          end else begin
            baddr <= trap_base;
            tsel  <= '0;
            st    <= L_TRAP;
          end
        end
        L_CODE: begin
          acc_b <= {acc_b[15:0], rd_byte};
          baddr <= baddr + 32'd1;
          bsel  <= bsel + 2'd1;
          if (bsel == 2'd3) begin
            ram_valid <= 1'b1; ram_kind <= K_DATA; ram_data <= word;
            widx <= widx + 32'd1;
            if (widx == wcnt[cpu] - 32'd1) st <= L_RDY;
          end
        end
        L_RDY: begin
          ram_valid <= 1'b1; ram_kind <= K_READY; ram_data <= 32'd1;
          baddr <= trap_base;
          tsel  <= '0;
          bsel  <= '0;
          st    <= L_TRAP;
        end
        L_TRAP: begin
          acc_b <= {acc_b[15:0], rd_byte};
          baddr <= baddr + 32'd1;
          bsel  <= bsel + 2'd1;
          if (bsel == 2'd3) begin
            if (word != 32'd0) begin
              trap_we <= 1'b1; trap_cpu <= cpu; trap_sel <= tsel; trap_data <= word;
            end
            tsel <= tsel + 4'd1;
            if (tsel == 4'd15) begin
              if (8'(cpu) == count - 8'd1) st <= L_END;
              else begin
                cpu <= cpu + CW'(1);
                st  <= L_DESC;
              end
            end
          end
        end
        L_END: begin
          fin <= 1'b1;
          st  <= L_IDLE;
        end
        default: st <= L_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ucode_loader.sv
module ucode_loader
  import ucl_pkg::*;
#(
  parameter int BUF_BYTES = 1024,
  parameter int MAX_CPU   = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        s_valid,
  output logic        s_ready,
  input  logic [7:0]  s_data,
  input  logic        s_last,
  output logic        ram_valid,
  output logic [1:0]  ram_kind,
  output logic [31:0] ram_data,
  output logic        split_set,
  output logic        trap_we,
  output logic [((MAX_CPU > 1) ? $clog2(MAX_CPU) : 1)-1:0] trap_cpu,
  output logic [3:0]  trap_sel,
  output logic [31:0] trap_data,
  output logic        done,
  output logic [2:0]  err
);
  localparam int AW = $clog2(BUF_BYTES);

  typedef enum logic [1:0] {T_RX, T_CHK, T_LOAD} tst_e;
  tst_e st;

  logic acc, clr, fin, start;
  logic [AW-1:0] rd_addr;
  logic [7:0]  rd_byte, version, count, split;
  logic [23:0] magic;
  logic [31:0] decl_len, rx_cnt, crc, trailer;
  logic        ovf;
  logic [MAX_CPU-1:0][31:0] ram_off, code_off, wcnt;
  logic [2:0]  chk_err;

  assign s_ready = (st == T_RX);
  assign acc     = s_valid && s_ready;
  assign start   = (st == T_CHK) && (chk_err == E_NONE);
  assign clr     = ((st == T_CHK) && (chk_err != E_NONE)) || fin;

  ucl_rx #(.BUF_BYTES(BUF_BYTES), .MAX_CPU(MAX_CPU)) rx_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .acc(acc), .din(s_data),
    .rd_addr(rd_addr), .rd_byte(rd_byte), .decl_len(decl_len), .magic(magic),
    .version(version), .count(count), .split(split), .ram_off(ram_off),
    .code_off(code_off), .wcnt(wcnt), .rx_cnt(rx_cnt), .ovf(ovf),
    .crc(crc), .trailer(trailer)
  );

  ucl_check #(.MAX_CPU(MAX_CPU)) chk_i (
    .decl_len(decl_len), .magic(magic), .version(version), .count(count),
    .wcnt(wcnt), .rx_cnt(rx_cnt), .ovf(ovf), .crc(crc), .trailer(trailer),
    .err(chk_err)
  );

  ucl_seq #(.AW(AW), .MAX_CPU(MAX_CPU)) seq_i (
    .clk(clk), .rst_n(rst_n), .start(start), .count(count), .split(split),
    .ram_off(ram_off), .code_off(code_off), .wcnt(wcnt), .rd_byte(rd_byte),
    .rd_addr(rd_addr), .ram_valid(ram_valid), .ram_kind(ram_kind),
    .ram_data(ram_data), .split_set(split_set), .trap_we(trap_we),
    .trap_cpu(trap_cpu), .trap_sel(trap_sel), .trap_data(trap_data), .fin(fin)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= T_RX; done <= 1'b0; err <= E_NONE;
    end else begin
      if (acc) begin
        done <= 1'b0; err <= E_NONE;
      end
      unique case (st)
        T_RX:   if (acc && s_last) st <= T_CHK;
        T_CHK: begin
          if (chk_err != E_NONE) begin
            done <= 1'b1; err <= chk_err; st <= T_RX;
          end else st <= T_LOAD;
        end
        T_LOAD: if (fin) begin
          done <= 1'b1; err <= E_NONE; st <= T_RX;
        end
        default: st <= T_RX;
      endcase
    end
  end
endmodule

// File: rtl/ucl_checker.sv
module ucl_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        s_valid,
  input logic        s_ready,
  input logic        ram_valid,
  input logic [1:0]  ram_kind,
  input logic        split_set,
  input logic        trap_we,
  input logic [31:0] trap_data,
  input logic        done,
  input logic [2:0]  err
);
  p_no_write_while_rx_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_valid || trap_we || split_set) |-> !s_ready);

  p_err_only_with_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (err != 3'd0) |-> done);

  p_trap_nonzero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    trap_we |-> (trap_data != 32'd0));

  p_kind_defined_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ram_valid |-> (ram_kind != 2'd0));

  p_split_alone_r7: assert property (@(posedge clk) disable iff (!rst_n)
    split_set |-> (!ram_valid && !trap_we));

  p_done_clears_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> (!done && err == 3'd0));
endmodule

bind ucode_loader ucl_checker chk_bind_i (
  .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
  .ram_valid(ram_valid), .ram_kind(ram_kind), .split_set(split_set),
  .trap_we(trap_we), .trap_data(trap_data), .done(done), .err(err)
);

// File: tb/ucode_loader_tb_top.sv
module ucode_loader_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s_valid = 1'b0, s_last = 1'b0;
  logic [7:0] s_data = '0;
  logic s_ready, ram_valid, split_set, trap_we, done;
  logic [1:0] ram_kind, trap_cpu;
  logic [31:0] ram_data, trap_data;
  logic [3:0] trap_sel;
  logic [2:0] err;

  always #5 clk = ~clk;

  ucode_loader dut_i (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .s_last(s_last), .ram_valid(ram_valid), .ram_kind(ram_kind),
    .ram_data(ram_data), .split_set(split_set), .trap_we(trap_we),
    .trap_cpu(trap_cpu), .trap_sel(trap_sel), .trap_data(trap_data),
    .done(done), .err(err)
  );

  int checks = 0, errors = 0;

  // image under construction
  logic [7:0]  img [0:1023];
  int          img_len;
  int          d_cnt;
  logic        d_split;
  logic        d_code [4];
  logic [31:0] d_ram [4], d_coff [4], d_wcnt [4];
  logic [31:0] d_trap [4][16];

  // write logs
  logic [1:0]  r_kind [0:255];
  logic [31:0] r_data [0:255];
  int          r_n;
  logic [1:0]  t_cpu [0:127];
  logic [3:0]  t_sel [0:127];
  logic [31:0] t_data [0:127];
  int          t_n, split_n;
  logic        split_late;
  logic        first_done;
  logic [2:0]  first_err;

  always @(negedge clk) begin
    if (ram_valid && r_n < 256) begin r_kind[r_n] = ram_kind; r_data[r_n] = ram_data; r_n++; end
    if (trap_we && t_n < 128) begin t_cpu[t_n] = trap_cpu; t_sel[t_n] = trap_sel; t_data[t_n] = trap_data; t_n++; end
    if (split_set) begin split_n++; if (r_n != 0 || t_n != 0) split_late = 1'b1; end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] crc_b(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r = c ^ {24'd0, b};
    for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    return r;
  endfunction

  task automatic put32(input int pos, input logic [31:0] v);
    img[pos] = v[31:24]; img[pos+1] = v[23:16]; img[pos+2] = v[15:8]; img[pos+3] = v[7:0];
  endtask

  task automatic seal_crc();
    logic [31:0] c = 32'd0;
    for (int i = 0; i < img_len - 4; i++) c = crc_b(c, img[i]);
    put32(img_len - 4, c);
  endtask

  function automatic logic [31:0] code_word(input int d, input int w);
    return {8'hA5, 8'(d), 16'(w * 7 + 1)};
  endfunction

  task automatic assemble();
    int pos = 10 + 76 * d_cnt;
    for (int d = 0; d < d_cnt; d++) begin
      if (d_code[d]) begin
        d_coff[d] = pos;
        for (int w = 0; w < int'(d_wcnt[d]); w++) begin put32(pos, code_word(d, w)); pos += 4; end
      end else d_coff[d] = 0;
    end
    img_len = pos + 4;
    put32(0, img_len);
    img[4] = 8'h51; img[5] = 8'h45; img[6] = 8'h46; img[7] = 8'd1;
    img[8] = 8'(d_cnt); img[9] = {7'd0, d_split};
    for (int d = 0; d < d_cnt; d++) begin
      put32(10 + 76*d, d_ram[d]);
      put32(14 + 76*d, d_coff[d]);
      put32(18 + 76*d, d_wcnt[d]);
      for (int t = 0; t < 16; t++) put32(22 + 76*d + 4*t, d_trap[d][t]);
    end
    seal_crc();
  endtask

  task automatic clear_desc();
    for (int d = 0; d < 4; d++) begin
      d_code[d] = 1'b0; d_ram[d] = '0; d_wcnt[d] = '0;
      for (int t = 0; t < 16; t++) d_trap[d][t] = '0;
    end
  endtask

  task automatic send_img();
    r_n = 0; t_n = 0; split_n = 0; split_late = 1'b0;
    for (int i = 0; i < img_len; i++) begin
      if (i % 5 == 3) begin @(negedge clk); s_valid = 1'b0; end
      @(negedge clk);
      s_valid = 1'b1; s_data = img[i]; s_last = (i == img_len - 1);
      while (!s_ready) @(negedge clk);
      @(negedge clk);
      s_valid = 1'b0; s_last = 1'b0;
      if (i == 0) begin first_done = done; first_err = err; end
    end
    for (int n = 0; n < 20000 && !done; n++) @(negedge clk);
    chk("R11 done after image", {31'd0, done}, 32'd1);
  endtask

  task automatic check_writes(input string tag);
    int e = 0;
    int te = 0;
    for (int d = 0; d < d_cnt; d++) begin
      if (d_code[d]) begin
        chk({tag, " R8 addr kind"}, {30'd0, r_kind[e]}, 32'd1);
        chk({tag, " R8 addr data"}, r_data[e], d_ram[d]); e++;
        for (int w = 0; w < int'(d_wcnt[d]); w++) begin
          chk({tag, " R8 code kind"}, {30'd0, r_kind[e]}, 32'd2);
          chk({tag, " R8 code word"}, r_data[e], code_word(d, w)); e++;
        end
        chk({tag, " R8 ready kind"}, {30'd0, r_kind[e]}, 32'd3);
        chk({tag, " R8 ready data"}, r_data[e], 32'd1); e++;
      end
      for (int t = 0; t < 16; t++) if (d_trap[d][t] != 0) begin
        chk({tag, " R10 trap cpu"}, {30'd0, t_cpu[te]}, d);
        chk({tag, " R10 trap sel"}, {28'd0, t_sel[te]}, t);
        chk({tag, " R10 trap data"}, t_data[te], d_trap[d][t]); te++;
      end
    end
    chk({tag, " R8 R9 ram write count"}, r_n, e);
    chk({tag, " R10 trap write count"}, t_n, te);
    chk({tag, " R7 split pulses"}, split_n, d_split ? 0 : 1);
    chk({tag, " R7 split first"}, {31'd0, split_late}, 32'd0);
  endtask

  task automatic expect_reject(input string tag, input logic [2:0] code);
    send_img();
    chk({tag, " err code"}, {29'd0, err}, {29'd0, code});
    chk({tag, " R11 no ram writes"}, r_n, 0);
    chk({tag, " R11 no trap writes"}, t_n, 0);
    chk({tag, " R11 no split"}, split_n, 0);
  endtask

  task automatic base_image();
    clear_desc();
    d_cnt = 1; d_split = 1'b0; d_code[0] = 1'b1; d_ram[0] = 32'h40; d_wcnt[0] = 2;
    d_trap[0][2] = 32'h0000_0022;
    assemble();
  endtask

  task automatic t_reset();
    chk("R11 reset s_ready", {31'd0, s_ready}, 32'd1);
    chk("R11 reset done", {31'd0, done}, 32'd0);
    chk("R11 reset err", {29'd0, err}, 32'd0);
    chk("R8 reset ram_valid", {31'd0, ram_valid}, 32'd0);
  endtask

  task automatic t_two_desc();
    clear_desc();
    d_cnt = 2; d_split = 1'b0;
    d_code[0] = 1'b1; d_ram[0] = 32'h100; d_wcnt[0] = 3;
    d_trap[0][0] = 32'h11; d_trap[0][15] = 32'hFFFF_0001;
    d_code[1] = 1'b0; d_ram[1] = 32'h200;             // R9: reuses code, no upload
    d_trap[1][3] = 32'h33;
    assemble();
    send_img();
    chk("two R5 valid image err", {29'd0, err}, 32'd0);
    check_writes("two");
  endtask

  task automatic t_four_desc();
    clear_desc();
    d_cnt = 4; d_split = 1'b1;
    d_code[0] = 1'b1; d_ram[0] = 32'h10; d_wcnt[0] = 1; d_trap[0][7] = 32'h7;
    d_code[1] = 1'b1; d_ram[1] = 32'h20; d_wcnt[1] = 0;
    d_code[2] = 1'b0; d_trap[2][0] = 32'h8000_0000; d_trap[2][1] = 32'h1;
    d_code[3] = 1'b1; d_ram[3] = 32'h30; d_wcnt[3] = 2; d_trap[3][14] = 32'hDEAD_BEEF;
    assemble();
    send_img();
    chk("four R5 valid image err", {29'd0, err}, 32'd0);
    check_writes("four");
  endtask

  task automatic t_bad_magic();
    base_image(); img[5] = 8'h58; seal_crc();
    expect_reject("R1 bad magic", 3'd1);
  endtask

  task automatic t_bad_version();
    base_image(); img[7] = 8'd2; seal_crc();
    expect_reject("R2 bad version", 3'd2);
  endtask

  task automatic t_bad_count();
    base_image(); img[8] = 8'd0; seal_crc();
    expect_reject("R3 count zero", 3'd3);
    base_image(); img[8] = 8'd5; seal_crc();
    expect_reject("R3 count five", 3'd3);
  endtask

  task automatic t_bad_len();
    base_image(); put32(0, img_len + 4); seal_crc();
    expect_reject("R4 declared length", 3'd4);
    base_image(); put32(18, 32'd3); seal_crc();
    expect_reject("R4 word count sum", 3'd4);
  endtask

  task automatic t_bad_crc();
    base_image(); img[img_len - 1] = img[img_len - 1] ^ 8'h01;
    expect_reject("R5 crc", 3'd5);
  endtask

  task automatic t_priority();
    base_image(); img[4] = 8'h00; img[7] = 8'd9; img[8] = 8'd7;
    expect_reject("R6 magic outranks", 3'd1);
    base_image(); img[7] = 8'd0; img[8] = 8'd0; put32(0, 32'd5);
    expect_reject("R6 version outranks", 3'd2);
  endtask

  task automatic t_hold();
    base_image(); img[img_len - 2] = img[img_len - 2] ^ 8'h10;
    expect_reject("R12 prep", 3'd5);
    repeat (12) @(negedge clk);
    chk("R12 done held", {31'd0, done}, 32'd1);
    chk("R12 err held", {29'd0, err}, 32'd5);
    base_image();
    send_img();
    chk("R12 done cleared by first byte", {31'd0, first_done}, 32'd0);
    chk("R12 err cleared by first byte", {29'd0, first_err}, 32'd0);
    chk("R12 next image ok", {29'd0, err}, 32'd0);
    check_writes("hold");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    r_n = 0; t_n = 0; split_n = 0; split_late = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_two_desc();
    t_four_desc();
    t_bad_magic();
    t_bad_version();
    t_bad_count();
    t_bad_len();
    t_bad_crc();
    t_priority();
    t_hold();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule